// File: doc/BRIEF.md
# Touch Sample FIFO with Status

This block buffers touch-panel samples between a measurement engine and a 32-bit register interface. Each sample arrives as a pen-up flag with a 10-bit X code and a 10-bit Y code. The block stores it in an eight-entry first-in first-out queue and hands it to software as one packed 32-bit word. Software polls a status word for the empty and overrun conditions. Each read of the data word pops the oldest entry, so reading until the empty flag appears flushes the queue.

Samples enter on a valid/ready stream. `smp_ready` is high whenever the queue has a free slot. The measurement engine cannot stall, so it may present `smp_valid` while `smp_ready` is low. That sample is then dropped and the sticky overrun flag is set. A pop and a push in the same cycle are both honoured when the queue is not full. When it is full, the push in that cycle is dropped.

An interrupt line goes high while the queue holds four or more entries, provided the four-entry interrupt enable in the control word is set.

Top module: `touch_fifo`

## Requirements
- R1: After reset the status word reads 0x00000080, `irq` is low, `smp_ready` is high and the control word reads 0.
- R2: A data word carries the pen-up flag in bit 31 (1 = pen up, 0 = pen down), X in bits 25:16 and Y in bits 9:0. Bits 30:26 and 15:10 read as zero.
- R3: Reads of the data word at offset 0x0C return the stored samples oldest first. Each such read removes one entry.
- R4: With eight entries held, `smp_ready` is low. A sample offered then is discarded and the stored contents do not change.
- R5: A discarded sample sets status bit 8 (overrun). The bit then stays set while entries remain.
- R6: Overrun clears on the clock edge at which a data read removes the last entry.
- R7: A data read while empty returns zero and leaves the queue untouched. The next sample pushed is the next one read.
- R8: Status word at offset 0x00: bit 7 is 1 exactly when the queue is empty. All bits other than 7 and 8 read zero.
- R9: `irq` is high exactly when control bit 11 is set and at least four entries are held.
- R10: The control word at offset 0x08 is writable. Only bit 11 is kept, and it reads back at the same position.
- R11: `reg_rd_data` is updated on the clock edge at which `reg_rd_en` is sampled and holds its value until the next read. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample offered by the measurement engine |
| smp_ready | output | 1 | Free slot available; sample accepted when valid |
| smp_pen_up | input | 1 | Pen-up flag of the offered sample |
| smp_x | input | 10 | X code of the offered sample |
| smp_y | input | 10 | Y code of the offered sample |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_data | output | 32 | Registered read data |
| irq | output | 1 | Four-entry fill interrupt |

## Verification
Several outputs depend only on the fill level and the control bit: the fill count, `smp_ready`, `irq` and the flags. These change on the clock edge that accepts a sample, a pop or a control write, so each is valid straight after that edge. Read data appears on the edge that samples `reg_rd_en`, one edge after the strobe is driven. The bench drives every input on a falling edge and samples on the next falling edge. Each check therefore falls exactly one rising edge after its stimulus, and no check depends on process order at an edge.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int COORD_W  = 10;
  localparam int WORD_W   = 32;
  localparam int REG_AW   = 8;

  // packed word field placement (software decodes these positions)
  localparam int PEN_BIT  = 31;
  localparam int X_LSB    = 16;
  localparam int Y_LSB    = 0;

  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h00;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 8'h08;
  localparam logic [REG_AW-1:0] OFS_DATA   = 8'h0C;

  localparam int ST_OVR_BIT    = 8;
  localparam int ST_EMPTY_BIT  = 7;
  localparam int CTRL_IRQ4_BIT = 11;
  localparam logic [WORD_W-1:0] CTRL_MASK = WORD_W'(1) << CTRL_IRQ4_BIT;

  typedef struct packed {
    logic               pen_up;
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } sample_t;

  function automatic logic [WORD_W-1:0] pack_word(sample_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[PEN_BIT]            = s.pen_up;
    w[X_LSB +: COORD_W]   = s.x;
    w[Y_LSB +: COORD_W]   = s.y;
    return w;
  endfunction
endpackage

// File: rtl/tsf_fifo.sv
module tsf_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_req,
  input  sample_t                       push_data,
  input  logic                          pop_req,
  output sample_t                       head,
  output logic [$clog2(DEPTH+1)-1:0]    fill_cnt,
  output logic                          full,
  output logic                          empty,
  output logic                          overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  sample_t          mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q;
  logic             accept, drop, pop;

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign accept = push_req && !full;
  assign drop   = push_req && full;
  assign pop    = pop_req && !empty;

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      if (pop)    rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      unique case ({accept, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // sticky overrun, released only by the pop that empties the queue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (drop) begin
      ovr_q <= 1'b1;
    end else if (pop && !accept && cnt_q == CNT_W'(1)) begin
      ovr_q <= 1'b0;
    end
  end

  assign head     = mem[rd_ptr];
  assign fill_cnt = cnt_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [WORD_W-1:0]  ctrl_word,
  output logic               irq4_en
);
  logic [WORD_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en && wr_addr == OFS_CTRL) begin
      ctrl_q <= wr_data & CTRL_MASK;
    end
  end

  assign ctrl_word = ctrl_q;
  assign irq4_en   = ctrl_q[CTRL_IRQ4_BIT];
endmodule

// File: rtl/tsf_rdport.sv
module tsf_rdport
  import tsf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [REG_AW-1:0]  rd_addr,
  input  logic               q_empty,
  input  logic               q_overrun,
  input  sample_t            q_head,
  input  logic [WORD_W-1:0]  ctrl_word,
  output logic               pop_req,
  output logic [WORD_W-1:0]  rd_data
);
  logic [WORD_W-1:0] status_w, data_w, next_w;

  always_comb begin
    status_w = '0;
    status_w[ST_OVR_BIT]   = q_overrun;
    status_w[ST_EMPTY_BIT] = q_empty;
  end

  assign data_w  = q_empty ? '0 : pack_word(q_head);
  assign pop_req = rd_en && (rd_addr == OFS_DATA);

  always_comb begin
    unique case (rd_addr)
      OFS_STATUS: next_w = status_w;
      OFS_CTRL:   next_w = ctrl_word;
      OFS_DATA:   next_w = data_w;
      default:    next_w = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= next_w;
  end
endmodule

// File: rtl/touch_fifo.sv
module touch_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int IRQ_LEVEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic               smp_pen_up,
  input  logic [COORD_W-1:0] smp_x,
  input  logic [COORD_W-1:0] smp_y,
  input  logic               reg_wr_en,
  input  logic [REG_AW-1:0]  reg_wr_addr,
  input  logic [WORD_W-1:0]  reg_wr_data,
  input  logic               reg_rd_en,
  input  logic [REG_AW-1:0]  reg_rd_addr,
  output logic [WORD_W-1:0]  reg_rd_data,
  output logic               irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  sample_t           in_smp, head_smp;
  logic [CNT_W-1:0]  fill_cnt;
  logic              q_full, q_empty, ovr_flag, pop_req, irq4_en;
  logic [WORD_W-1:0] ctrl_word;

  assign in_smp = '{pen_up: smp_pen_up, x: smp_x, y: smp_y};

  tsf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (smp_valid),
    .push_data(in_smp),
    .pop_req  (pop_req),
    .head     (head_smp),
    .fill_cnt (fill_cnt),
    .full     (q_full),
    .empty    (q_empty),
    .overrun  (ovr_flag)
  );

  tsf_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_wr_addr),
    .wr_data  (reg_wr_data),
    .ctrl_word(ctrl_word),
    .irq4_en  (irq4_en)
  );

  tsf_rdport u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (reg_rd_en),
    .rd_addr  (reg_rd_addr),
    .q_empty  (q_empty),
    .q_overrun(ovr_flag),
    .q_head   (head_smp),
    .ctrl_word(ctrl_word),
    .pop_req  (pop_req),
    .rd_data  (reg_rd_data)
  );

  assign smp_ready = !q_full;
  assign irq       = irq4_en && (fill_cnt >= CNT_W'(IRQ_LEVEL));
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker
  import tsf_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int IRQ_LEVEL = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       smp_valid,
  input logic                       smp_ready,
  input logic                       reg_wr_en,
  input logic                       reg_rd_en,
  input logic [REG_AW-1:0]          reg_rd_addr,
  input logic [WORD_W-1:0]          reg_rd_data,
  input logic                       irq,
  input logic [$clog2(DEPTH+1)-1:0] fill_cnt,
  input logic                       ovr_flag
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic data_rd;
  assign data_rd = reg_rd_en && (reg_rd_addr == OFS_DATA);

  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(DEPTH));

  assert_drop_sets_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> ovr_flag);

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !(data_rd && fill_cnt == CNT_W'(1))) |=> ovr_flag);

  assert_ovr_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && data_rd && !smp_valid && fill_cnt == CNT_W'(1)) |=> !ovr_flag);

  assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fill_cnt == '0 && !smp_valid) |=> (reg_rd_data == '0 && fill_cnt == '0));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(smp_valid || reg_wr_en));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rd_data));
endmodule

bind touch_fifo tsf_checker #(.DEPTH(DEPTH), .IRQ_LEVEL(IRQ_LEVEL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .smp_ready  (smp_ready),
  .reg_wr_en  (reg_wr_en),
  .reg_rd_en  (reg_rd_en),
  .reg_rd_addr(reg_rd_addr),
  .reg_rd_data(reg_rd_data),
  .irq        (irq),
  .fill_cnt   (fill_cnt),
  .ovr_flag   (ovr_flag)
);

// File: tb/touch_fifo_bench.sv
module touch_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0, smp_pen_up = 1'b0;
  logic [9:0]  smp_x = '0, smp_y = '0;
  logic        smp_ready;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_wr_addr = '0, reg_rd_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  touch_fifo u_touch_fifo (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_pen_up(smp_pen_up),
    .smp_x(smp_x), .smp_y(smp_y),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .irq(irq)
  );

  // {pen_up, x, y}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 10'h000, 10'h3FF}, {1'b1, 10'h3FF, 10'h000},
    {1'b0, 10'h155, 10'h2AA}, {1'b1, 10'h2AA, 10'h155},
    {1'b0, 10'h001, 10'h200}, {1'b0, 10'h200, 10'h001},
    {1'b1, 10'h123, 10'h321}, {1'b0, 10'h3FE, 10'h07F}
  };

  function automatic logic [31:0] expect_word(logic [20:0] v);
    return {v[20], 5'b0, v[19:10], 6'b0, v[9:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [20:0] v);
    @(negedge clk);
    smp_valid = 1'b1; {smp_pen_up, smp_x, smp_y} = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_rd_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rd_data;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R8 reset state
    rd(8'h00, d); check("R1 status", d, 32'h80);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 ready", {31'b0, smp_ready}, 32'h1);
    rd(8'h08, d); check("R1 ctrl", d, 32'h0);
    rd(8'h04, d); check("R11 other offset", d, 32'h0);

    // R10 control write and mask
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R10 ctrl mask", d, 32'h800);

    // vector table: fill to full, check irq and ready at each level
    foreach (VEC[i]) begin
      push(VEC[i]);
      check("R9 irq level", {31'b0, irq}, {31'b0, (i + 1) >= 4});
      check("R4 ready level", {31'b0, smp_ready}, {31'b0, (i + 1) < 8});
      if (i == 0) begin
        rd(8'h00, d); check("R8 not empty", d, 32'h0);
      end
    end

    // R4 / R5 sample while full is dropped, overrun set
    push({1'b1, 10'h0AA, 10'h0BB});
    rd(8'h00, d); check("R5 overrun set", d, 32'h100);

    // R2 / R3 drain in order; R5 sticky; R6 clear on final pop
    foreach (VEC[i]) begin
      rd(8'h0C, d); check("R3 R2 data order", d, expect_word(VEC[i]));
      // R11 held while no read
      @(negedge clk); check("R11 hold", reg_rd_data, expect_word(VEC[i]));
      rd(8'h00, d);
      check(i < 7 ? "R5 sticky" : "R6 cleared", d, i < 7 ? 32'h100 : 32'h80);
    end

    // R7 empty read
    rd(8'h0C, d); check("R7 empty data", d, 32'h0);
    rd(8'h00, d); check("R7 status after empty read", d, 32'h80);
    push({1'b0, 10'h111, 10'h222});
    rd(8'h0C, d); check("R7 pointers intact", d, expect_word({1'b0, 10'h111, 10'h222}));

    // R9 enable gating
    wr(8'h08, 32'h0);
    for (int k = 0; k < 4; k++) push(VEC[k]);
    check("R9 irq disabled", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h800);
    check("R9 irq enabled", {31'b0, irq}, 32'h1);
    rd(8'h0C, d);
    check("R9 irq below level", {31'b0, irq}, 32'h0);
    for (int k = 1; k < 4; k++) begin
      rd(8'h0C, d); check("R3 second fill order", d, expect_word(VEC[k]));
    end
    rd(8'h00, d); check("R8 empty again", d, 32'h80);

    finish_run();
  end
endmodule